// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Controller

This block sits between a processor's instruction fetch port and a bus master port that keeps at most one transaction in flight. It holds a direct-mapped, read-only array of instruction lines. A fetch that hits returns the stored word in the same cycle and never raises the miss output. A fetch that misses raises the miss (stall) output in that same cycle. The controller then issues one read burst for the whole line and writes the words into the line as they arrive. The stall ends once the line is complete, and the held fetch hits on the following cycle.

A set of address windows, given as parameters, marks memory as uncached. A fetch that falls inside one of these windows bypasses the array. It issues a one-word read at the exact fetch address and presents the returned word on the fetch port for one cycle, with the miss output low. The array is left untouched. Only line fills write the array, and the processor never does. If the bus flags an error on any word of a fill, the line stays invalid and the error output rises for one cycle in place of the stall.

Top module: `icache_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first fetch to any cached address misses. With no fetch pending, the miss and error outputs are low and no bus command is asserted.
- R2: A cached fetch that hits drives the stored word on `fetch_instr` with `fetch_miss` low in the same cycle as the request.
- R3: A cached fetch that misses raises `fetch_miss` in the request cycle and keeps it high until the last word of the line has been written. With a bus that accepts the command at once and returns one word per cycle, this takes exactly WORDS+2 cycles.
- R4: A cached miss issues exactly one command with `bus_cmd_plen` equal to WORDS. Its address is the fetch address with the low log2(WORDS)+2 bits cleared. Address and length stay stable while the command waits for `bus_cmd_ack`.
- R5: Response words are written to word offsets 0, 1, 2 and onward in arrival order. Afterwards every word of the line hits with the data at its own address, and no further bus command is issued.
- R6: A new command is never asserted until every response word of the previous command has been received.
- R7: A fetch inside an uncached window issues a one-word read (`bus_cmd_plen`=1) at the exact fetch address. It keeps `fetch_miss` high for 3 cycles with an immediate bus, then returns the word for one cycle with `fetch_miss` low. It allocates nothing, so repeating the same fetch issues another bus read.
- R8: If `bus_rsp_err` is high on any word of a fill, `fetch_err` rises for one cycle with `fetch_miss` low, after the same WORDS+2 stall cycles. The line stays invalid, so the next fetch to it misses again.
- R9: Two cached addresses with equal index bits (address bits [log2(WORDS)+2 +: log2(LINES)]) and different tags evict each other, so alternating between them misses every time.
- R10: Without `fetch_req` the block starts no bus command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Processor fetch request, held while stalled |
| fetch_addr | input | 32 | Byte address of the fetch (word aligned) |
| fetch_instr | output | 32 | Fetched instruction word (Mealy) |
| fetch_miss | output | 1 | Stall: the word is not yet available (Mealy) |
| fetch_err | output | 1 | One-cycle bus error report for the current fetch |
| bus_cmd_val | output | 1 | Read command valid |
| bus_cmd_ack | input | 1 | Command accepted by the bus |
| bus_cmd_addr | output | 32 | Start byte address of the read |
| bus_cmd_plen | output | 6 | Number of words requested |
| bus_rsp_val | input | 1 | Response word valid |
| bus_rsp_data | input | 32 | Response word |
| bus_rsp_err | input | 1 | Error flag for this response word |

## Verification
The bench counts stall cycles from the request. A request applied after a falling edge is sampled 1 ns later, and again after each later falling edge until `fetch_miss` drops. A cached miss must give exactly WORDS+2 stall samples and an uncached fetch exactly 3. A hit or a returned word is checked in that same sample, because the outputs are combinational in the request and the state. The bench's bus model acknowledges a command one cycle after it appears, streams one word per cycle, records each command's address and length, and flags any command raised while responses are still due. The checks therefore compare the command address, the length, the command count and the data against values computed from the requirements.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_RSP  = 2'd2,
        ST_DONE = 2'd3
    } fill_state_e;

    typedef struct packed {
        logic        val;
        logic [31:0] addr;
        logic [5:0]  plen;
    } bus_cmd_t;

    typedef struct packed {
        logic        hit;
        logic [31:0] word;
    } lookup_t;

endpackage

// File: rtl/icache_seg_check.sv
module icache_seg_check #(
    parameter int                 NSEG   = 1,
    parameter logic [NSEG*32-1:0] UNC_LO = {NSEG{32'hF000_0000}},
    parameter logic [NSEG*32-1:0] UNC_HI = {NSEG{32'hFFFF_FFFF}}
) (
    input  logic [31:0] addr,
    output logic        uncached
);
    logic [NSEG-1:0] in_seg;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign in_seg[g] = (addr >= UNC_LO[g*32 +: 32]) && (addr <= UNC_HI[g*32 +: 32]);
    end

    assign uncached = |in_seg;
endmodule

// File: rtl/icache_store.sv
module icache_store
    import icache_pkg::*;
#(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    localparam int IDXW = $clog2(LINES),
    localparam int OFFW = $clog2(WORDS),
    localparam int TAGW = 32 - IDXW - OFFW - 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [OFFW-1:0] rd_off,
    input  logic [TAGW-1:0] rd_tag,
    output lookup_t         rd,
    input  logic            inv_en,
    input  logic [IDXW-1:0] inv_idx,
    input  logic [TAGW-1:0] inv_tag,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [OFFW-1:0] wr_off,
    input  logic [31:0]     wr_data,
    input  logic            cm_en,
    input  logic [IDXW-1:0] cm_idx
);
    logic [31:0]     data_q [LINES*WORDS];
    logic [TAGW-1:0] tag_q  [LINES];
    logic [LINES-1:0] vld_q;

    assign rd.hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd.word = data_q[{rd_idx, rd_off}];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (inv_en) begin
                vld_q[inv_idx] <= 1'b0;
            end
            if (cm_en) begin
                vld_q[cm_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (inv_en) begin
            tag_q[inv_idx] <= inv_tag;
        end
        if (wr_en) begin
            data_q[{wr_idx, wr_off}] <= wr_data;
        end
    end

    // A line may only become valid after the miss that claimed it cleared it.
    assert_fill_after_inval_R8 : assert property (@(posedge clk) disable iff (rst)
        cm_en |-> !vld_q[cm_idx]);

    // The same line is never claimed and completed in one cycle.
    assert_no_claim_and_commit_R5 : assert property (@(posedge clk) disable iff (rst)
        !(inv_en && cm_en));
endmodule

// File: rtl/icache_fill_fsm.sv
module icache_fill_fsm
    import icache_pkg::*;
#(
    parameter int LINES = 16,
    parameter int WORDS = 4,
    localparam int IDXW = $clog2(LINES),
    localparam int OFFW = $clog2(WORDS),
    localparam int TAGW = 32 - IDXW - OFFW - 2,
    localparam logic [31:0] LINE_MASK = 32'(WORDS * 4 - 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_req,
    input  logic [31:0]     fetch_addr,
    input  logic            uncached,
    input  logic            hit,
    output logic            miss,
    output logic            err,
    output logic            use_buf,
    output logic [31:0]     buf_word,
    output bus_cmd_t        cmd,
    input  logic            cmd_ack,
    input  logic            rsp_val,
    input  logic [31:0]     rsp_data,
    input  logic            rsp_err,
    output logic            inv_en,
    output logic [IDXW-1:0] inv_idx,
    output logic [TAGW-1:0] inv_tag,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [OFFW-1:0] wr_off,
    output logic            cm_en
);
    fill_state_e state_q, state_d;
    logic [31:0] addr_q;
    logic        unc_q;
    logic        err_q;
    logic [5:0]  cnt_q;
    logic [31:0] buf_q;
    logic        start, last, bad;

    assign start = (state_q == ST_IDLE) && fetch_req && !(hit && !uncached);
    assign cmd.val  = (state_q == ST_CMD);
    assign cmd.plen = unc_q ? 6'd1 : 6'(WORDS);
    assign cmd.addr = unc_q ? addr_q : (addr_q & ~LINE_MASK);
    assign last = (cnt_q == cmd.plen - 6'd1);
    assign bad  = err_q || rsp_err;

    assign inv_en  = start && !uncached;
    assign inv_idx = fetch_addr[OFFW+2 +: IDXW];
    assign inv_tag = fetch_addr[31 -: TAGW];
    assign wr_en   = (state_q == ST_RSP) && rsp_val && !unc_q;
    assign wr_idx  = addr_q[OFFW+2 +: IDXW];
    assign wr_off  = cnt_q[OFFW-1:0];
    assign cm_en   = wr_en && last && !bad;

    assign miss     = start || (state_q == ST_CMD) || (state_q == ST_RSP);
    assign err      = (state_q == ST_DONE) && err_q;
    assign use_buf  = (state_q == ST_DONE);
    assign buf_word = buf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CMD;
            ST_CMD:  if (cmd_ack) state_d = ST_RSP;
            ST_RSP:  if (rsp_val && last) state_d = (unc_q || bad) ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            unc_q   <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                addr_q <= fetch_addr;
                unc_q  <= uncached;
                err_q  <= 1'b0;
                cnt_q  <= '0;
            end else if ((state_q == ST_RSP) && rsp_val) begin
                cnt_q <= cnt_q + 6'd1;
                err_q <= bad;
                buf_q <= rsp_data;
            end
        end
    end

    // One transaction at a time: no command while responses are due.
    assert_one_outstanding_R6 : assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RSP) |-> !cmd.val);

    // A waiting command holds its address and length.
    assert_cmd_stable_R4 : assert property (@(posedge clk) disable iff (rst)
        (cmd.val && !cmd_ack) |=> (cmd.val && $stable(cmd.addr) && $stable(cmd.plen)));

    // Response phase is only entered through an accepted command.
    assert_cmd_before_rsp_R4 : assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RSP) && ($past(state_q) != ST_RSP)) |-> ($past(state_q) == ST_CMD));

    // A burst length is either one line or one word.
    assert_plen_legal_R7 : assert property (@(posedge clk) disable iff (rst)
        cmd.val |-> ((cmd.plen == 6'(WORDS)) || (cmd.plen == 6'd1)));

    // No request means no new command starts.
    assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && !fetch_req) |=> !cmd.val);
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int                 LINES  = 16,
    parameter int                 WORDS  = 4,
    parameter int                 NSEG   = 1,
    parameter logic [NSEG*32-1:0] UNC_LO = {NSEG{32'hF000_0000}},
    parameter logic [NSEG*32-1:0] UNC_HI = {NSEG{32'hFFFF_FFFF}}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_req,
    input  logic [31:0] fetch_addr,
    output logic [31:0] fetch_instr,
    output logic        fetch_miss,
    output logic        fetch_err,
    output logic        bus_cmd_val,
    input  logic        bus_cmd_ack,
    output logic [31:0] bus_cmd_addr,
    output logic [5:0]  bus_cmd_plen,
    input  logic        bus_rsp_val,
    input  logic [31:0] bus_rsp_data,
    input  logic        bus_rsp_err
);
    localparam int IDXW = $clog2(LINES);
    localparam int OFFW = $clog2(WORDS);
    localparam int TAGW = 32 - IDXW - OFFW - 2;

    logic            uncached;
    lookup_t         rd;
    bus_cmd_t        cmd;
    logic            use_buf;
    logic [31:0]     buf_word;
    logic            inv_en, wr_en, cm_en;
    logic [IDXW-1:0] inv_idx, wr_idx;
    logic [TAGW-1:0] inv_tag;
    logic [OFFW-1:0] wr_off;

    icache_seg_check #(.NSEG(NSEG), .UNC_LO(UNC_LO), .UNC_HI(UNC_HI)) u_seg (
        .addr     (fetch_addr),
        .uncached (uncached)
    );

    icache_store #(.LINES(LINES), .WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (fetch_addr[OFFW+2 +: IDXW]),
        .rd_off  (fetch_addr[2 +: OFFW]),
        .rd_tag  (fetch_addr[31 -: TAGW]),
        .rd      (rd),
        .inv_en  (inv_en),
        .inv_idx (inv_idx),
        .inv_tag (inv_tag),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_off  (wr_off),
        .wr_data (bus_rsp_data),
        .cm_en   (cm_en),
        .cm_idx  (wr_idx)
    );

    icache_fill_fsm #(.LINES(LINES), .WORDS(WORDS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .uncached   (uncached),
        .hit        (rd.hit),
        .miss       (fetch_miss),
        .err        (fetch_err),
        .use_buf    (use_buf),
        .buf_word   (buf_word),
        .cmd        (cmd),
        .cmd_ack    (bus_cmd_ack),
        .rsp_val    (bus_rsp_val),
        .rsp_data   (bus_rsp_data),
        .rsp_err    (bus_rsp_err),
        .inv_en     (inv_en),
        .inv_idx    (inv_idx),
        .inv_tag    (inv_tag),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_off     (wr_off),
        .cm_en      (cm_en)
    );

    assign fetch_instr  = use_buf ? buf_word : rd.word;
    assign bus_cmd_val  = cmd.val;
    assign bus_cmd_addr = cmd.addr;
    assign bus_cmd_plen = cmd.plen;

    // Stall and error report are never raised together.
    assert_err_not_stalled_R8 : assert property (@(posedge clk) disable iff (rst)
        fetch_err |-> !fetch_miss);
endmodule

// File: tb/icache_ctrl_bench.sv
`timescale 1ns/1ps
module icache_ctrl_bench;
    localparam int WORDS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] fetch_instr;
    logic        fetch_miss, fetch_err;
    logic        bus_cmd_val;
    logic        bus_cmd_ack = 1'b0;
    logic [31:0] bus_cmd_addr;
    logic [5:0]  bus_cmd_plen;
    logic        bus_rsp_val = 1'b0;
    logic [31:0] bus_rsp_data = '0;
    logic        bus_rsp_err = 1'b0;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cmd_count = 0;
    int          overlap = 0;
    int          err_at = -1;
    logic [31:0] last_addr = '0;
    logic [5:0]  last_plen = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    icache_ctrl u_icache_ctrl (
        .clk (clk), .rst (rst),
        .fetch_req (fetch_req), .fetch_addr (fetch_addr),
        .fetch_instr (fetch_instr), .fetch_miss (fetch_miss), .fetch_err (fetch_err),
        .bus_cmd_val (bus_cmd_val), .bus_cmd_ack (bus_cmd_ack),
        .bus_cmd_addr (bus_cmd_addr), .bus_cmd_plen (bus_cmd_plen),
        .bus_rsp_val (bus_rsp_val), .bus_rsp_data (bus_rsp_data), .bus_rsp_err (bus_rsp_err)
    );

    function automatic logic [31:0] mem(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus model: ack one cycle after command, one word per cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_cmd_val && !rst) begin
                cmd_count++;
                last_addr = bus_cmd_addr;
                last_plen = bus_cmd_plen;
                bus_cmd_ack = 1'b1;
                @(negedge clk);
                bus_cmd_ack = 1'b0;
                for (int i = 0; i < int'(last_plen); i++) begin
                    bus_rsp_val  = 1'b1;
                    bus_rsp_data = mem(last_addr + 32'(4 * i));
                    bus_rsp_err  = (i == err_at);
                    @(negedge clk);
                    if (bus_cmd_val) overlap++;
                end
                bus_rsp_val = 1'b0;
                bus_rsp_err = 1'b0;
            end
        end
    end

    // Issues a fetch and counts stall samples until the word is available.
    task automatic do_fetch(input logic [31:0] a, output int stalls,
                            output logic [31:0] instr, output logic err);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        stalls = 0;
        for (int k = 0; k < 100; k++) begin
            #1;
            if (!fetch_miss) break;
            stalls++;
            @(negedge clk);
        end
        instr = fetch_instr;
        err   = fetch_err;
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check("R1 miss idle", 32'(fetch_miss), 0);
        check("R1 err idle", 32'(fetch_err), 0);
        check("R10 no cmd", 32'(bus_cmd_val), 0);
        repeat (3) @(negedge clk);
        check("R10 no cmd count", 32'(cmd_count), 0);
    endtask

    task automatic t_cold_miss();
        int s; logic [31:0] d; logic e;
        do_fetch(32'h0000_1008, s, d, e);
        check("R1 R3 cold miss stalls", 32'(s), 32'(WORDS + 2));
        check("R4 line address", last_addr, 32'h0000_1000);
        check("R4 line length", 32'(last_plen), 32'(WORDS));
        check("R3 data after fill", d, mem(32'h0000_1008));
        check("R4 one command", 32'(cmd_count), 1);
    endtask

    task automatic t_line_hits();
        int s; logic [31:0] d; logic e;
        for (int w = 0; w < WORDS; w++) begin
            do_fetch(32'h0000_1000 + 32'(4 * w), s, d, e);
            check("R2 hit no stall", 32'(s), 0);
            check("R5 word offset data", d, mem(32'h0000_1000 + 32'(4 * w)));
        end
        check("R5 no extra command", 32'(cmd_count), 1);
    endtask

    task automatic t_conflict();
        int s; logic [31:0] d; logic e;
        do_fetch(32'h0000_1104, s, d, e);
        check("R9 conflict miss B", 32'(s), 32'(WORDS + 2));
        check("R9 B data", d, mem(32'h0000_1104));
        check("R4 B aligned", last_addr, 32'h0000_1100);
        do_fetch(32'h0000_100C, s, d, e);
        check("R9 evicted A misses", 32'(s), 32'(WORDS + 2));
        check("R9 A data", d, mem(32'h0000_100C));
        check("R4 command per miss", 32'(cmd_count), 3);
    endtask

    task automatic t_uncached();
        int s; logic [31:0] d; logic e;
        do_fetch(32'hF000_0014, s, d, e);
        check("R7 uncached stalls", 32'(s), 3);
        check("R7 exact address", last_addr, 32'hF000_0014);
        check("R7 single word", 32'(last_plen), 1);
        check("R7 returned word", d, mem(32'hF000_0014));
        do_fetch(32'hF000_0014, s, d, e);
        check("R7 no allocation", 32'(cmd_count), 5);
        check("R7 repeat stalls", 32'(s), 3);
    endtask

    task automatic t_error();
        int s; logic [31:0] d; logic e;
        err_at = 2;
        do_fetch(32'h0000_2040, s, d, e);
        check("R8 error fill stalls", 32'(s), 32'(WORDS + 2));
        check("R8 error reported", 32'(e), 1);
        err_at = -1;
        do_fetch(32'h0000_2044, s, d, e);
        check("R8 line left invalid", 32'(s), 32'(WORDS + 2));
        check("R8 clean refill no err", 32'(e), 0);
        check("R8 refill data", d, mem(32'h0000_2044));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cold_miss();
        t_line_hits();
        t_conflict();
        t_uncached();
        t_error();
        repeat (4) @(negedge clk);
        check("R6 no overlapping command", 32'(overlap), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule